// File: doc/BRIEF.md
# Shared-Exponent Block Quantizer (FP32 to 4-bit elements)

This block turns a stream of FP32 words into a compact block-scaled form. Each block holds up to 32 words. The output is one power-of-two scale byte, followed by a 4-bit element code for every word. The scale byte is an exponent with no mantissa and a bias of 127. A consumer rebuilds each value as the element value times two raised to the scale. The element code has one sign bit, two exponent bits and one mantissa bit.

Words enter over a valid/ready stream that carries a last flag, and are stored in a one-block buffer. A running scan keeps the largest exponent and notes any NaN. A block closes on the word that carries the last flag, or on the 32nd word. The block then leaves over a byte-wide valid/ready stream: the scale byte first, then 16 bytes with two codes per byte. Input is refused while a block is being emitted.

Back-pressure follows the usual valid/ready rules. A beat moves on any rising edge where valid and ready are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. `in_ready` depends only on internal state, never on `in_valid`.

Top module: `mxq_block_quant`

## Requirements
- R1: A block closes on an accepted word with `in_last` high, or on the BLK-th accepted word (BLK=32), whichever comes first. `in_ready` is low from that point until the final output byte has been accepted.
- R2: The first output byte of a block is the scale: Emax-2, where Emax is the largest biased exponent field among the block's words. If Emax is below 2, the scale is 0.
- R3: If any word of the block is a NaN (exponent field 255, nonzero fraction), the scale byte is 0xFF and every element code of that block is 0.
- R4: A block of all zeros emits scale 0x00 and 16 data bytes of 0x00.
- R5: Each element is x / 2^(scale-127), rounded to the nearest of the magnitudes 0, 0.5, 1, 1.5, 2, 3, 4, 6. These are magnitude codes 0 to 7. Ties go to the even code. Bit 3 of the element is the sign, and a result of magnitude 0 is emitted as 0x0.
- R6: A scaled magnitude above 6 saturates to code 7. An infinite input gives code 7 with its sign.
- R7: After the scale byte come BLK/2 data bytes. Element 2k sits in bits 3:0 of data byte k and element 2k+1 in bits 7:4. `out_last` is high only on the final data byte.
- R8: In a block closed early by `in_last`, the positions that received no word are encoded as 0.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay stable.
- R10: Inputs with a zero exponent field (zeros and FP32 subnormals) are flushed. They give element code 0 and do not raise the scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 32 | FP32 input word |
| in_last | input | 1 | Word closes the current block |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Scale byte, then packed element codes |
| out_last | output | 1 | Final byte of the block |

## Verification
`out_valid` rises one cycle after the handshake on the closing word, and that cycle carries the scale byte. Each later data byte appears on the cycle after the previous byte was accepted. `in_ready` returns one cycle after the final byte's handshake.

The bench drives inputs and `out_ready` on the falling edge, then reads the outputs 1 ns later. A value is therefore counted as transferred on exactly the cycle whose rising edge completes the handshake. Any stall cycle is compared against the byte held from the previous cycle.

// File: rtl/mxq_pkg.sv
package mxq_pkg;
  localparam int unsigned FP_W    = 32;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 23;
  localparam int unsigned ELEM_W  = 4;
  localparam int unsigned EMAX_EL = 2;       // top exponent of the 4-bit element
  localparam logic [7:0]  NAN_SCALE = 8'hFF;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_SCALE = 2'd1,
    ST_DATA  = 2'd2
  } mxq_state_e;

  function automatic logic is_nan32(input logic [FP_W-1:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != '0);
  endfunction

  function automatic logic [EXP_W-1:0] scale_of(input logic [EXP_W-1:0] emax);
    return (emax >= EXP_W'(EMAX_EL)) ? emax - EXP_W'(EMAX_EL) : '0;
  endfunction
endpackage

// File: rtl/mxq_scan.sv
module mxq_scan
  import mxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             clear,
  input  logic [FP_W-1:0]  word,
  output logic [EXP_W-1:0] emax_q,
  output logic             nan_q
);
  logic [EXP_W-1:0] w_exp;
  logic             w_nan;

  assign w_exp = word[30:23];
  assign w_nan = is_nan32(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emax_q <= '0;
      nan_q  <= 1'b0;
    end else if (clear) begin
      emax_q <= '0;
      nan_q  <= 1'b0;
    end else if (take) begin
      if (!w_nan && (w_exp > emax_q)) emax_q <= w_exp;
      if (w_nan) nan_q <= 1'b1;
    end
  end

  // the running maximum never falls while a block is being scanned
  assert_max_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear) |=> (emax_q >= $past(emax_q)));

  // a NaN seen stays recorded until the block is released
  assert_nan_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nan_q && !clear) |=> nan_q);
endmodule

// File: rtl/mxq_blkbuf.sv
module mxq_blkbuf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/mxq_elem_enc.sv
module mxq_elem_enc
  import mxq_pkg::*;
(
  input  logic [FP_W-1:0]   word,
  input  logic              present,
  input  logic              nan_blk,
  input  logic [EXP_W-1:0]  scale,
  output logic [ELEM_W-1:0] nib
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] m;
  logic signed [9:0] d;
  logic              up;
  logic [3:0]        sum;
  logic [2:0]        mag;

  assign e = word[30:23];
  assign m = word[22:0];
  assign d = $signed({2'b00, e}) - $signed({2'b00, scale});

  always_comb begin
    up  = m[21] & ((|m[20:0]) | m[22]);
    sum = {1'b0, d[1:0] + 2'd1, m[22]} + {3'b000, up};
    mag = 3'd0;
    if (!present || nan_blk || (e == '0)) begin
      mag = 3'd0;
    end else if (e == 8'hFF) begin
      mag = 3'd7;
    end else if (d > 10'sd2) begin
      mag = 3'd7;
    end else if (d >= 10'sd0) begin
      mag = (sum > 4'd7) ? 3'd7 : sum[2:0];
    end else if (d == -10'sd1) begin
      mag = m[22] ? 3'd2 : 3'd1;
    end else if (d == -10'sd2) begin
      mag = (|m) ? 3'd1 : 3'd0;
    end else begin
      mag = 3'd0;
    end
  end

  assign nib = (mag == 3'd0) ? 4'h0 : {word[31], mag};

  // flushed inputs never yield a nonzero code
  always_comb begin
    if (present && (e == '0)) begin
      assert_flush_R10: assert (nib == 4'h0);
    end
  end
endmodule

// File: rtl/mxq_block_quant.sv
module mxq_block_quant
  import mxq_pkg::*;
#(
  parameter int unsigned BLK = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);
  localparam int unsigned IDXW  = $clog2(BLK);
  localparam int unsigned NBYTE = BLK / 2;
  localparam int unsigned BW    = $clog2(NBYTE);
  localparam int unsigned LANES = 2;

  mxq_state_e       st_q;
  logic [IDXW:0]    fill_q;
  logic [BW-1:0]    byte_q;
  logic             take, close, done;
  logic [EXP_W-1:0] emax;
  logic             nan_blk;
  logic [EXP_W-1:0] scale_b;
  logic [FP_W-1:0]  rd   [LANES];
  logic [3:0]       nibs [LANES];
  logic [IDXW-1:0]  ridx [LANES];

  assign in_ready  = (st_q == ST_FILL);
  assign out_valid = (st_q != ST_FILL);
  assign take      = in_valid && in_ready;
  assign close     = take && (in_last || (fill_q == (IDXW+1)'(BLK-1)));
  assign out_last  = (st_q == ST_DATA) && (byte_q == BW'(NBYTE-1));
  assign done      = out_last && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FILL;
      fill_q <= '0;
      byte_q <= '0;
    end else begin
      unique case (st_q)
        ST_FILL: begin
          if (take) fill_q <= fill_q + 1'b1;
          if (close) st_q <= ST_SCALE;
        end
        ST_SCALE: begin
          if (out_ready) begin
            st_q   <= ST_DATA;
            byte_q <= '0;
          end
        end
        ST_DATA: begin
          if (out_ready) begin
            if (out_last) begin
              st_q   <= ST_FILL;
              fill_q <= '0;
            end else begin
              byte_q <= byte_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end

  mxq_scan u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .clear  (done),
    .word   (in_data),
    .emax_q (emax),
    .nan_q  (nan_blk)
  );

  assign scale_b = scale_of(emax);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic present;
      assign ridx[l]  = {byte_q, 1'(l)};
      assign present  = ({1'b0, ridx[l]} < fill_q);
      mxq_elem_enc u_enc (
        .word    (rd[l]),
        .present (present),
        .nan_blk (nan_blk),
        .scale   (scale_b),
        .nib     (nibs[l])
      );
    end
  endgenerate

  mxq_blkbuf #(.DEPTH(BLK), .W(FP_W)) u_buf (
    .clk     (clk),
    .we      (take),
    .waddr   (fill_q[IDXW-1:0]),
    .wdata   (in_data),
    .raddr_a (ridx[0]),
    .raddr_b (ridx[1]),
    .rdata_a (rd[0]),
    .rdata_b (rd[1])
  );

  always_comb begin
    if (st_q == ST_SCALE) out_data = nan_blk ? NAN_SCALE : scale_b;
    else                  out_data = {nibs[1], nibs[0]};
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && !in_ready));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  assert_scale_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_last);

  assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= (IDXW+1)'(BLK));
endmodule

// File: tb/mxq_block_quant_tb.sv
module mxq_block_quant_tb;
  localparam int BLK = 32;
  localparam int NB  = BLK / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] blk [BLK];

  always #5 clk = ~clk;

  mxq_block_quant #(.BLK(BLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic real gridv(input int c);
    case (c)
      0: return 0.0; 1: return 0.5; 2: return 1.0; 3: return 1.5;
      4: return 2.0; 5: return 3.0; 6: return 4.0; default: return 6.0;
    endcase
  endfunction

  function automatic bit nan32(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic logic [7:0] exp_scale(input int n);
    int mx = 0;
    for (int i = 0; i < n; i++) begin
      if (nan32(blk[i])) return 8'hFF;
      if (int'(blk[i][30:23]) > mx) mx = int'(blk[i][30:23]);
    end
    return (mx >= 2) ? 8'(mx - 2) : 8'h00;
  endfunction

  function automatic logic [3:0] exp_elem(input logic [31:0] w, input int s);
    int e = int'(w[30:23]);
    real v, bd;
    int best = 0;
    if (e == 0) return 4'h0;
    if (e == 255) return {w[31], 3'd7};
    v = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (e - s));
    if (v > 6.0) best = 7;
    else begin
      bd = 100.0;
      for (int c = 0; c < 8; c++) begin
        real dd = (v > gridv(c)) ? v - gridv(c) : gridv(c) - v;
        if (dd < bd || (dd == bd && (c % 2) == 0)) begin bd = dd; best = c; end
      end
    end
    return (best == 0) ? 4'h0 : {w[31], 3'(best)};
  endfunction

  // drive one block of n words, then collect and check all output bytes
  task automatic run_block(input int n, input bit use_last, input string tag);
    int i = 0, k = 0;
    logic [7:0] sc, held, ebyte;
    logic [3:0] lo, hi;
    bit pend = 0;
    sc = exp_scale(n);
    while (i < n) begin
      @(negedge clk);
      if ($urandom % 5 == 0) in_valid = 1'b0;
      else begin
        in_valid = 1'b1; in_data = blk[i]; in_last = use_last && (i == n - 1);
        #1;
        if (in_ready) i++;
      end
    end
    while (k <= NB) begin
      bit rdy;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      rdy = ($urandom % 4) != 0;
      out_ready = rdy;
      #1;
      if (pend) chk("R9 stall hold", {1'b0, out_data}, {1'b0, held});
      pend = 0;
      if (k == 0 && out_valid) chk("R1 in_ready low while emitting", {8'h0, in_ready}, 9'h0);
      if (out_valid && rdy) begin
        if (k == 0) chk((sc == 8'hFF) ? "R3 scale" : "R2 scale", {out_last, out_data}, {1'b0, sc});
        else begin
          lo = (sc == 8'hFF || 2*(k-1) >= n) ? 4'h0 : exp_elem(blk[2*(k-1)], int'(sc));
          hi = (sc == 8'hFF || 2*(k-1)+1 >= n) ? 4'h0 : exp_elem(blk[2*(k-1)+1], int'(sc));
          ebyte = {hi, lo};
          chk({tag, " R7 data"}, {out_last, out_data}, {(k == NB), ebyte});
        end
        k++;
      end else if (out_valid) begin
        held = out_data; pend = 1;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk("R1 in_ready back", {8'h0, in_ready}, 9'h1);
  endtask

  function automatic logic [31:0] mk(input bit s, input int e, input int m);
    return {s, 8'(e), 23'(m)};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset in_ready", {8'h0, in_ready}, 9'h1);
    chk("R7 reset out_valid", {8'h0, out_valid}, 9'h0);
    rst_n = 1'b1;

    // R4 all-zero block
    for (int i = 0; i < BLK; i++) blk[i] = 32'h0;
    run_block(BLK, 0, "R4");

    // R5 ties: max 4.0 gives scale 127
    for (int i = 0; i < BLK; i++) blk[i] = 32'h0;
    blk[0] = mk(0,129,0);        blk[1] = mk(0,125,0);       // 4.0, 0.25
    blk[2] = mk(1,126,23'h400000); blk[3] = mk(0,127,23'h200000); // -0.75, 1.25
    blk[4] = mk(0,127,23'h600000); blk[5] = mk(0,128,23'h200000); // 1.75, 2.5
    blk[6] = mk(0,128,23'h600000); blk[7] = mk(1,129,23'h200000); // 3.5, -5
    blk[8] = mk(0,125,23'h400000); blk[9] = mk(0,126,23'h200000); // 0.375, 0.625
    blk[10] = mk(0,124,0);        blk[11] = mk(0,129,23'h7FFFFF);
    run_block(BLK, 0, "R5");

    // R6 saturation and infinity
    for (int i = 0; i < BLK; i++) blk[i] = mk(i % 2, 130, i * 4099);
    blk[3] = 32'hFF800000; blk[4] = mk(0,129,23'h600000);
    run_block(BLK, 1, "R6");

    // R3 NaN block
    for (int i = 0; i < BLK; i++) blk[i] = mk(0, 120 + i % 4, i * 777);
    blk[17] = 32'h7FC00001;
    run_block(BLK, 0, "R3");

    // R8 short block closed by last
    for (int i = 0; i < BLK; i++) blk[i] = 32'h0;
    for (int i = 0; i < 5; i++) blk[i] = mk(1, 140 - i, i * 123457);
    run_block(5, 1, "R8");

    // R10 subnormal inputs, tiny maximum exponent
    for (int i = 0; i < BLK; i++) blk[i] = mk(0, 0, 1000 + i);
    blk[2] = mk(0, 1, 5); blk[9] = mk(1, 0, 23'h7FFFFF);
    run_block(BLK, 0, "R10");

    // constrained random blocks
    for (int b = 0; b < 40; b++) begin
      int eb = 60 + int'($urandom % 130);
      int n  = (b % 7 == 3) ? 1 + int'($urandom % BLK) : BLK;
      for (int i = 0; i < BLK; i++) begin
        int m = int'($urandom % 8388608);
        if ($urandom % 3 == 0) m = m & 32'h700000;
        blk[i] = ($urandom % 9 == 0) ? 32'h0 :
                 mk($urandom % 2, eb - int'($urandom % 7), m);
      end
      run_block(n, (n < BLK) || (b % 2 == 0), "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule